// File: doc/BRIEF.md
# Audio Serial Clock Prescaler

This block produces the timing for a serial audio port that drives its own clocks. From one kernel clock it derives a master clock for an external converter, a bit clock, a word-select line and a one-cycle frame strobe that a serializer uses to align its shift register. A programmable divider sets the base rate. The divider value comes from an 8-bit coarse field and a single odd-adjust bit, so every integer ratio from 1 to 511 can be reached, except one setting that is rejected.

The master clock output can be enabled or disabled. When it is enabled, the divided clock is the master clock, and the bit clock is a further fixed division of it. That fixed divisor is the master-to-sample ratio (256 in the two-channel formats, 128 in the pulse-framed format) divided by the frame length. When the master clock is disabled, the divided clock is used directly as the bit clock. A channel-width bit selects 16 or 32 bits per channel. A mode bit selects between a two-channel frame, where word-select marks the channel, and a pulse-framed format, where word-select marks only the first bit. A polarity bit inverts the bit clock. An idle control bit chooses what the lines do while the port is disabled. Settings are captured only at frame boundaries, so a retune never produces a shortened pulse.

Top module: `aud_clkgen`

## Requirements
- R1: The divide ratio is R = 2*div_i + odd_i. With the master clock enabled, mclk_o is high for ceil(R/2) kernel cycles and low for floor(R/2) kernel cycles in each period.
- R2: When div_i=0 and odd_i=0 (ratio 1), the kernel clock itself appears on mclk_o while the port runs with the master clock enabled.
- R3: div_i=1 with odd_i=1 is illegal. Once it is captured, cfg_err_o is 1, mclk_o, ck_o and ws_o keep their last values, and frame_o stays 0. When a legal value is captured, a new frame starts from its beginning.
- R4: With the master clock enabled, the bit clock period is R*K kernel cycles with 50% duty. K is 8 for 16-bit channels and 4 for 32-bit channels, in both frame modes.
- R5: With the master clock disabled, mclk_o stays 0 and ck_o is the divided clock: high ceil(R/2) and low floor(R/2) kernel cycles.
- R6: With bit time T, chan32_i selects 16 (0) or 32 (1) bits per channel. In two-channel mode (dsp_i=0), ws_o is 0 for the first channel and 1 for the second, each lasting CH*T. In pulse mode (dsp_i=1), ws_o is 1 for the first bit only (T cycles) and 0 for the other CH-1 bits.
- R7: frame_o pulses for one kernel cycle at the first cycle of every frame. Its period is T times the frame length (2*CH in two-channel mode, CH in pulse mode). In that cycle the uninverted bit clock is high.
- R8: ck_inv_i=1 inverts ck_o, so ck_o is 0 in the frame_o cycle.
- R9: While en_i is 0, mclk_o and ws_o are 0. ck_o is ck_inv_i when idle_hold_i is 1, and 0 when idle_hold_i is 0. Reset leaves all outputs at 0.
- R10: A change to div_i, odd_i or the mode bits while running takes effect only from the next frame start. The rest of the current frame keeps the old timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Port enable |
| div_i | input | 8 | Coarse divide field |
| odd_i | input | 1 | Adds one to the doubled divide field |
| mclk_en_i | input | 1 | Master clock output enable |
| chan32_i | input | 1 | 1: 32-bit channels, 0: 16-bit channels |
| dsp_i | input | 1 | 1: pulse-framed mode, 0: two-channel mode |
| ck_inv_i | input | 1 | Bit clock inversion |
| idle_hold_i | input | 1 | Drive inactive clock levels while disabled |
| mclk_o | output | 1 | Master clock |
| ck_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select |
| frame_o | output | 1 | One-cycle frame start strobe |
| cfg_err_o | output | 1 | Illegal divider setting captured |

## Verification
Every legal small ratio, both even and odd, is swept with the master clock on and off. The measured high and low times separate an off-by-one in the odd-ratio duty split from an error in the doubling of the coarse field. A full matrix of channel width, frame mode and master-clock enable, at a fixed ratio, shows whether the fixed bit-clock divisor, the word-select shape and the frame length are each chosen by the correct bit. The ratio is changed in the middle of a frame to show that the old timing runs until the frame ends. The illegal code, the bypass code and the idle levels are each driven on their own to observe the hold, the pass-through and the polarity choices.

// File: rtl/aud_clkgen_pkg.sv
package aud_clkgen_pkg;
  parameter int unsigned DIV_W       = 8;
  parameter int unsigned CH_SHORT    = 16;
  parameter int unsigned CH_LONG     = 32;
  parameter int unsigned MCLK_FS_STD = 256;
  parameter int unsigned MCLK_FS_DSP = 128;

  localparam int unsigned RATIO_W = DIV_W + 2;
  localparam int unsigned BIT_W   = $clog2(2 * CH_LONG) + 1;
  localparam int unsigned SUB_W   = $clog2(MCLK_FS_STD / (2 * CH_SHORT)) + 1;

  typedef logic [RATIO_W-1:0] ratio_t;
  typedef logic [BIT_W-1:0]   bit_t;
  typedef logic [SUB_W-1:0]   sub_t;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             odd;
    logic             mclk_en;
    logic             chan32;
    logic             dsp;
  } shape_t;

  // doubled coarse field plus odd bit; zero is promoted to one (bypass)
  function automatic ratio_t eff_ratio(shape_t s);
    ratio_t r;
    r = {1'b0, s.div, s.odd};
    if (r == '0) r = ratio_t'(1);
    return r;
  endfunction

  function automatic logic bad_setting(shape_t s);
    return (s.div == DIV_W'(1)) && s.odd;
  endfunction

  // high phase takes the extra cycle of an odd ratio
  function automatic ratio_t high_time(ratio_t r);
    return ratio_t'((r + ratio_t'(1)) >> 1);
  endfunction

  function automatic bit_t chan_bits(shape_t s);
    return s.chan32 ? bit_t'(CH_LONG) : bit_t'(CH_SHORT);
  endfunction

  function automatic bit_t frame_bits(shape_t s);
    return s.dsp ? chan_bits(s) : bit_t'(chan_bits(s) << 1);
  endfunction

  // master clock periods per bit clock period
  function automatic sub_t sub_per_bit(shape_t s);
    int unsigned fs_ratio;
    fs_ratio = s.dsp ? MCLK_FS_DSP : MCLK_FS_STD;
    return sub_t'(fs_ratio / 32'(frame_bits(s)));
  endfunction
endpackage

// File: rtl/aud_clkgen_shadow.sv
module aud_clkgen_shadow
  import aud_clkgen_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  logic   frame_end_i,
  input  shape_t shape_i,
  output shape_t shape_o,
  output logic   bad_o
);
  logic load;

  assign bad_o = bad_setting(shape_o);
  // capture while idle, while rejected, or at the end of a frame
  assign load  = !en_i || bad_o || frame_end_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   shape_o <= '0;
    else if (load) shape_o <= shape_i;
  end
endmodule

// File: rtl/aud_clkgen_divider.sv
module aud_clkgen_divider
  import aud_clkgen_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   run_i,
  input  logic   clear_i,
  input  ratio_t ratio_i,
  output ratio_t cnt_o,
  output logic   tick_o,
  output logic   level_o
);
  ratio_t cnt_q;

  assign cnt_o   = cnt_q;
  assign tick_o  = run_i && (cnt_q >= ratio_i - ratio_t'(1));
  assign level_o = cnt_q < high_time(ratio_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (run_i)   cnt_q <= tick_o ? '0 : cnt_q + ratio_t'(1);
  end

  // R1
  div_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q < ratio_i);

  // R1
  div_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && tick_o |=> cnt_q == '0);
endmodule

// File: rtl/aud_clkgen_framer.sv
module aud_clkgen_framer
  import aud_clkgen_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   run_i,
  input  logic   clear_i,
  input  logic   tick_i,
  input  logic   level_i,
  input  shape_t shape_i,
  output logic   frame_end_o,
  output logic   start_o,
  output logic   ck_raw_o,
  output logic   ws_raw_o
);
  sub_t sub_q, m;
  bit_t bit_q, fb, ch;
  logic bit_end;

  assign m  = sub_per_bit(shape_i);
  assign fb = frame_bits(shape_i);
  assign ch = chan_bits(shape_i);

  assign bit_end     = tick_i && (!shape_i.mclk_en || sub_q == m - sub_t'(1));
  assign frame_end_o = bit_end && (bit_q == fb - bit_t'(1));
  assign start_o     = (sub_q == '0) && (bit_q == '0);
  assign ck_raw_o    = shape_i.mclk_en ? (sub_q < (m >> 1)) : level_i;
  assign ws_raw_o    = shape_i.dsp ? (bit_q == '0) : (bit_q >= ch);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= '0;
      bit_q <= '0;
    end else if (clear_i) begin
      sub_q <= '0;
      bit_q <= '0;
    end else if (run_i) begin
      if (tick_i && shape_i.mclk_en) sub_q <= bit_end ? '0 : sub_q + sub_t'(1);
      if (bit_end) bit_q <= frame_end_o ? '0 : bit_q + bit_t'(1);
    end
  end

  // R4
  sub_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && shape_i.mclk_en |-> sub_q < m);

  // R6
  ws_chan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && bit_end && !shape_i.dsp && (bit_q == ch - bit_t'(1)) |=> ws_raw_o);

  // R7
  frame_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && frame_end_o |=> start_o);
endmodule

// File: rtl/aud_clkgen.sv
module aud_clkgen
  import aud_clkgen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             odd_i,
  input  logic             mclk_en_i,
  input  logic             chan32_i,
  input  logic             dsp_i,
  input  logic             ck_inv_i,
  input  logic             idle_hold_i,
  output logic             mclk_o,
  output logic             ck_o,
  output logic             ws_o,
  output logic             frame_o,
  output logic             cfg_err_o
);
  shape_t shape_in, shape_q;
  ratio_t ratio, dcnt;
  logic   cfg_bad, run, clear;
  logic   tick, level, frame_end, start, ck_raw, ws_raw;
  logic   mclk_q, ck_q, ws_q, fs_q, mbyp_q, cbyp_q;

  assign shape_in = '{div: div_i, odd: odd_i, mclk_en: mclk_en_i,
                      chan32: chan32_i, dsp: dsp_i};
  assign run   = en_i && !cfg_bad;
  assign clear = !en_i;
  assign ratio = eff_ratio(shape_q);

  aud_clkgen_shadow u_shadow (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .frame_end_i(frame_end),
    .shape_i(shape_in), .shape_o(shape_q), .bad_o(cfg_bad)
  );

  aud_clkgen_divider u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .clear_i(clear),
    .ratio_i(ratio), .cnt_o(dcnt), .tick_o(tick), .level_o(level)
  );

  aud_clkgen_framer u_frm (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .clear_i(clear),
    .tick_i(tick), .level_i(level), .shape_i(shape_q),
    .frame_end_o(frame_end), .start_o(start), .ck_raw_o(ck_raw), .ws_raw_o(ws_raw)
  );

  // output stage: idle levels, hold on a rejected setting, else follow counters
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mclk_q <= 1'b0; ck_q <= 1'b0; ws_q <= 1'b0;
      fs_q <= 1'b0; mbyp_q <= 1'b0; cbyp_q <= 1'b0;
    end else if (!en_i) begin
      mclk_q <= 1'b0;
      ck_q   <= idle_hold_i & ck_inv_i;
      ws_q   <= 1'b0;
      fs_q   <= 1'b0;
      mbyp_q <= 1'b0;
      cbyp_q <= 1'b0;
    end else if (cfg_bad) begin
      fs_q <= 1'b0;
    end else begin
      mclk_q <= shape_q.mclk_en && level;
      ck_q   <= ck_raw ^ ck_inv_i;
      ws_q   <= ws_raw;
      fs_q   <= start && (dcnt == '0);
      mbyp_q <= shape_q.mclk_en && (ratio == ratio_t'(1));
      cbyp_q <= !shape_q.mclk_en && (ratio == ratio_t'(1));
    end
  end

  // ratio 1 routes the kernel clock itself; ck_q then holds the inverse of the polarity bit
  assign mclk_o    = mbyp_q ? (clk_i & mclk_q) : mclk_q;
  assign ck_o      = cbyp_q ? (clk_i ^ !ck_q) : ck_q;
  assign ws_o      = ws_q;
  assign frame_o   = fs_q;
  assign cfg_err_o = cfg_bad;

  // R3
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && cfg_bad |=> $stable(ck_q) && $stable(ws_q) && $stable(mclk_q) && !fs_q);

  // R9
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (ck_o == $past(idle_hold_i && ck_inv_i)) && !ws_o && !mclk_o);

  // R5
  mclk_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !cfg_bad && !shape_q.mclk_en |=> !mclk_o);

  // R10
  shape_at_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run) && run && !$stable(shape_q) |-> start && (dcnt == '0));
endmodule

// File: tb/aud_clkgen_test.sv
module aud_clkgen_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [7:0] div = '0;
  logic odd = 0, men = 0, c32 = 0, dsp = 0, inv = 0, idle = 0;
  logic mclk, ck, ws, frm, err;
  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  aud_clkgen uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .div_i(div), .odd_i(odd),
    .mclk_en_i(men), .chan32_i(c32), .dsp_i(dsp), .ck_inv_i(inv),
    .idle_hold_i(idle), .mclk_o(mclk), .ck_o(ck), .ws_o(ws),
    .frame_o(frm), .cfg_err_o(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int sig(input int sel);
    case (sel)
      0: return int'(mclk);
      1: return int'(ck);
      2: return int'(ws);
      default: return int'(frm);
    endcase
  endfunction

  task automatic meas(input int sel, output int hi, output int lo);
    int guard = 0;
    hi = 0; lo = 0;
    while (sig(sel) != 0 && guard < 20000) begin @(negedge clk); guard++; end
    while (sig(sel) != 1 && guard < 20000) begin @(negedge clk); guard++; end
    while (sig(sel) == 1 && guard < 20000) begin hi++; @(negedge clk); guard++; end
    while (sig(sel) == 0 && guard < 20000) begin lo++; @(negedge clk); guard++; end
  endtask

  task automatic wait_frame(output int seen);
    int guard = 0;
    seen = 0;
    while (!frm && guard < 20000) begin @(negedge clk); guard++; end
    if (frm) seen = 1;
  endtask

  task automatic restart(input int d, input int o, input int m, input int w,
                         input int p, input int iv, input int ih);
    @(negedge clk);
    en = 0;
    div = 8'(d); odd = 1'(o); men = 1'(m); c32 = 1'(w); dsp = 1'(p);
    inv = 1'(iv); idle = 1'(ih);
    cyc(3);
    en = 1;
  endtask

  function automatic int ratio_of(input int d, input int o);
    int r = d + d + o;
    return (r == 0) ? 1 : r;
  endfunction

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: got 0 expected 1 (run completion)");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int hi, lo, r, t, ch, fb, sub, seen, cnt;
    logic c0, w0, m0;
    cyc(5);
    rst_n = 1;
    cyc(2);
    // R9 reset state
    chk("R9 reset ck", int'(ck), 0);
    chk("R9 reset ws", int'(ws), 0);
    chk("R9 reset mclk", int'(mclk), 0);
    chk("R9 reset frame", int'(frm), 0);
    chk("R3 reset err", int'(err), 0);

    // R1 and R5: sweep of legal ratios
    for (int d = 1; d <= 6; d++) begin
      for (int o = 0; o <= 1; o++) begin
        if (d == 1 && o == 1) continue;
        r = ratio_of(d, o);
        restart(d, o, 1, 0, 0, 0, 0);
        meas(0, hi, lo);
        chk($sformatf("R1 mclk high r=%0d", r), hi, (r + 1) / 2);
        chk($sformatf("R1 mclk low r=%0d", r), lo, r / 2);
        restart(d, o, 0, 0, 0, 0, 0);
        meas(1, hi, lo);
        chk($sformatf("R5 ck high r=%0d", r), hi, (r + 1) / 2);
        chk($sformatf("R5 ck low r=%0d", r), lo, r / 2);
        cnt = 0;
        for (int k = 0; k < 30; k++) begin @(negedge clk); cnt += int'(mclk); end
        chk($sformatf("R5 mclk quiet r=%0d", r), cnt, 0);
      end
    end

    // R4 R6 R7: mode matrix at ratio 4
    for (int m = 0; m <= 1; m++)
      for (int w = 0; w <= 1; w++)
        for (int p = 0; p <= 1; p++) begin
          r  = 4;
          ch = w ? 32 : 16;
          fb = p ? ch : 2 * ch;
          sub = (p ? 128 : 256) / fb;
          t  = m ? r * sub : r;
          restart(2, 0, m, w, p, 0, 0);
          meas(1, hi, lo);
          chk($sformatf("R4 ck high m=%0d w=%0d p=%0d", m, w, p), hi, m ? t / 2 : 2);
          chk($sformatf("R4 ck low m=%0d w=%0d p=%0d", m, w, p), lo, m ? t / 2 : 2);
          meas(2, hi, lo);
          chk($sformatf("R6 ws high m=%0d w=%0d p=%0d", m, w, p), hi, p ? t : ch * t);
          chk($sformatf("R6 ws low m=%0d w=%0d p=%0d", m, w, p), lo, p ? (ch - 1) * t : ch * t);
          meas(3, hi, lo);
          chk($sformatf("R7 frame pulse m=%0d w=%0d p=%0d", m, w, p), hi, 1);
          chk($sformatf("R7 frame gap m=%0d w=%0d p=%0d", m, w, p), lo, fb * t - 1);
          wait_frame(seen);
          chk("R7 ck high at frame start", int'(ck), 1);
        end

    // R8: inverted bit clock
    restart(2, 0, 0, 0, 0, 1, 0);
    wait_frame(seen);
    chk("R8 ck low at frame start", int'(ck), 0);
    meas(1, hi, lo);
    chk("R8 inverted ck high", hi, 2);
    chk("R8 inverted ck low", lo, 2);

    // R9: idle levels
    @(negedge clk); en = 0; inv = 1; idle = 1;
    cyc(2);
    chk("R9 idle hold ck", int'(ck), 1);
    chk("R9 idle ws", int'(ws), 0);
    chk("R9 idle mclk", int'(mclk), 0);
    idle = 0;
    cyc(2);
    chk("R9 no hold ck", int'(ck), 0);

    // R2: bypass ratio
    restart(0, 0, 1, 0, 0, 0, 0);
    cyc(5);
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); #1;
      chk("R2 mclk high phase", int'(mclk), 1);
      @(negedge clk); #1;
      chk("R2 mclk low phase", int'(mclk), 0);
    end

    // R3: illegal setting holds, then recovers
    restart(1, 1, 1, 0, 0, 0, 0);
    cyc(3);
    chk("R3 err flagged", int'(err), 1);
    c0 = ck; w0 = ws; m0 = mclk; cnt = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (ck != c0 || ws != w0 || mclk != m0 || frm) cnt++;
    end
    chk("R3 outputs held", cnt, 0);
    odd = 0; div = 8'd2;
    wait_frame(seen);
    chk("R3 resume frame", seen, 1);
    chk("R3 err cleared", int'(err), 0);

    // R10: ratio change mid-frame waits for the boundary
    restart(2, 0, 0, 0, 0, 0, 0);
    wait_frame(seen);
    cyc(10);
    div = 8'd3;
    meas(1, hi, lo);
    chk("R10 old ratio high", hi, 2);
    chk("R10 old ratio low", lo, 2);
    wait_frame(seen);
    meas(1, hi, lo);
    chk("R10 new ratio high", hi, 3);
    chk("R10 new ratio low", lo, 3);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule